// File: doc/BRIEF.md
# Host Port Request Generator

This block sits between a host register bus and a processing core. It holds one receive data word, which the core loads and the host takes, and one transmit data word, which the host loads and the core drains. Each word has a flag: receive-full marks a word waiting for the host, and transmit-empty marks room for a new host word. A three-bit control register lets the host choose which flags may raise a request line toward it. The same register chooses how the two request pins are used.

The pins have two modes. In single mode, pin A carries one combined request, active low, and pin B is held inactive; the acknowledge input is only sampled. In dual mode, pin A carries only the transmit request and pin B carries only the receive request. A direction whose enable is clear never requests, so the host must poll the status word for it. Both request pins are registered: each one follows the flag or enable state one clock later.

Top module: `hrq_port`

## Requirements
- R1: A host write to address 0 loads the control register from write-data bits 2:0: bit 0 is the receive request enable, bit 1 is the transmit request enable, bit 2 selects dual mode. A read of address 0 returns these bits with zeros above. Address 3 reads as zero and ignores writes.
- R2: After reset the control register is 0, receive-full is 0, transmit-empty is 1, both data words are 0, and both request pins are high.
- R3: A core receive write sets receive-full and stores the core word. A host read of address 2 returns the stored receive word in the same cycle and clears receive-full.
- R4: A host write to address 2 stores the transmit word and clears transmit-empty. A core transmit read sees the stored word on core_tx_data in that cycle and sets transmit-empty.
- R5: In single mode, req_tx_n is low exactly one clock after a cycle in which (receive enable AND receive-full) OR (transmit enable AND transmit-empty) held.
- R6: In dual mode, req_tx_n is low one clock after a cycle in which transmit enable AND transmit-empty held, and req_rx_n is low one clock after a cycle in which receive enable AND receive-full held. Each pin ignores the other direction.
- R7: In single mode req_rx_n stays high. With an enable at 0, its flag never pulls any pin low.
- R8: A read of address 1 returns bit 0 receive-full, bit 1 transmit-empty, and bit 2 the acknowledge input as sampled at the previous clock edge. The acknowledge input never changes a flag.
- R9: When a core receive write and a host read of address 2 fall in the same cycle, the host gets the old word, receive-full stays 1, and the new core word is kept.
- R10: When a host write of address 2 and a core transmit read fall in the same cycle, the core gets the old word, transmit-empty ends at 0, and the new host word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host bus access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 control, 1 status, 2 data, 3 unused |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, combinational from address |
| core_rx_wr | input | 1 | Core loads the receive word |
| core_rx_data | input | DW | Word loaded by the core |
| core_tx_rd | input | 1 | Core drains the transmit word |
| core_tx_data | output | DW | Stored transmit word |
| host_ack | input | 1 | Acknowledge from host, sampled only |
| req_tx_n | output | 1 | Combined request (single) or transmit request (dual), active low |
| req_rx_n | output | 1 | Receive request in dual mode, high in single mode |

## Verification
Two pairs of operations can fall in the same cycle. On the receive side, the core can load a word while the host reads the data address. On the transmit side, the host can write the data address while the core drains it. Random traffic makes both collisions happen often, and directed cycles force each one. The bench judges the outcome by comparing with a reference model: the read data or core data seen in the colliding cycle must be the old word, the flag must end in the loading side's state, and the new word must come back on the next access.

// File: rtl/hrq_pkg.sv
package hrq_pkg;

    localparam int unsigned ADDR_W = 2;
    localparam int unsigned CTRL_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } hrq_addr_e;

    // packed MSB first: dual is bit 2, tx_en bit 1, rx_en bit 0
    typedef struct packed {
        logic dual;
        logic tx_en;
        logic rx_en;
    } hrq_ctrl_t;

endpackage

// File: rtl/hrq_ctrl.sv
module hrq_ctrl
    import hrq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_bits,
    output hrq_ctrl_t           ctrl_q
);

    typedef struct packed {
        hrq_ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl = hrq_ctrl_t'(wr_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;

endmodule

// File: rtl/hrq_buffers.sv
module hrq_buffers #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_rd_stb,
    input  logic          host_wr_stb,
    input  logic [DW-1:0] host_wdata,
    input  logic          core_rx_wr,
    input  logic [DW-1:0] core_rx_data,
    input  logic          core_tx_rd,
    input  logic          ack_in,
    output logic [DW-1:0] rx_word,
    output logic [DW-1:0] tx_word,
    output logic          rx_full,
    output logic          tx_empty,
    output logic          ack_seen
);

    typedef struct packed {
        logic [DW-1:0] rx_word;
        logic [DW-1:0] tx_word;
        logic          rx_full;
        logic          tx_empty;
        logic          ack_seen;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ack_seen = ack_in;
        // receive side: a core load outranks a host drain
        if (host_rd_stb) begin
            st_d.rx_full = 1'b0;
        end
        if (core_rx_wr) begin
            st_d.rx_full = 1'b1;
            st_d.rx_word = core_rx_data;
        end
        // transmit side: a host load outranks a core drain
        if (core_tx_rd) begin
            st_d.tx_empty = 1'b1;
        end
        if (host_wr_stb) begin
            st_d.tx_empty = 1'b0;
            st_d.tx_word  = host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.tx_empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_word  = st_q.rx_word;
    assign tx_word  = st_q.tx_word;
    assign rx_full  = st_q.rx_full;
    assign tx_empty = st_q.tx_empty;
    assign ack_seen = st_q.ack_seen;

endmodule

// File: rtl/hrq_reqgen.sv
module hrq_reqgen
    import hrq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hrq_ctrl_t ctrl,
    input  logic      rx_full,
    input  logic      tx_empty,
    output logic      req_a_n,
    output logic      req_b_n
);

    typedef struct packed {
        logic a_n;
        logic b_n;
    } state_t;

    state_t st_d, st_q;
    logic   rx_want, tx_want;

    always_comb begin
        rx_want = ctrl.rx_en & rx_full;
        tx_want = ctrl.tx_en & tx_empty;
        if (ctrl.dual) begin
            st_d.a_n = ~tx_want;
            st_d.b_n = ~rx_want;
        end else begin
            st_d.a_n = ~(tx_want | rx_want);
            st_d.b_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_a_n = st_q.a_n;
    assign req_b_n = st_q.b_n;

endmodule

// File: rtl/hrq_port.sv
module hrq_port
    import hrq_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    input  logic              core_rx_wr,
    input  logic [DW-1:0]     core_rx_data,
    input  logic              core_tx_rd,
    output logic [DW-1:0]     core_tx_data,
    input  logic              host_ack,
    output logic              req_tx_n,
    output logic              req_rx_n
);

    localparam int unsigned STAT_W = 3;

    hrq_addr_e     addr;
    hrq_ctrl_t     ctrl_q;
    logic          ctrl_wr, data_wr, data_rd;
    logic [DW-1:0] rx_word;
    logic          rx_full, tx_empty, ack_seen;
    logic          unused_wdata_hi;

    assign addr    = hrq_addr_e'(host_addr);
    assign ctrl_wr = host_sel &  host_wr & (addr == ADDR_CTRL);
    assign data_wr = host_sel &  host_wr & (addr == ADDR_DATA);
    assign data_rd = host_sel & ~host_wr & (addr == ADDR_DATA);
    assign unused_wdata_hi = ^host_wdata;

    hrq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wr_bits (host_wdata[CTRL_W-1:0]),
        .ctrl_q  (ctrl_q)
    );

    hrq_buffers #(.DW(DW)) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_rd_stb  (data_rd),
        .host_wr_stb  (data_wr),
        .host_wdata   (host_wdata),
        .core_rx_wr   (core_rx_wr),
        .core_rx_data (core_rx_data),
        .core_tx_rd   (core_tx_rd),
        .ack_in       (host_ack),
        .rx_word      (rx_word),
        .tx_word      (core_tx_data),
        .rx_full      (rx_full),
        .tx_empty     (tx_empty),
        .ack_seen     (ack_seen)
    );

    hrq_reqgen u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl_q),
        .rx_full  (rx_full),
        .tx_empty (tx_empty),
        .req_a_n  (req_tx_n),
        .req_b_n  (req_rx_n)
    );

    always_comb begin
        host_rdata = '0;
        case (addr)
            ADDR_CTRL: host_rdata[CTRL_W-1:0] = ctrl_q;
            ADDR_STAT: host_rdata[STAT_W-1:0] = {ack_seen, tx_empty, rx_full};
            ADDR_DATA: host_rdata             = rx_word;
            default:   host_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/hrq_port_chk.sv
module hrq_port_chk
    import hrq_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input hrq_ctrl_t ctrl,
    input logic      rx_full,
    input logic      tx_empty,
    input logic      core_rx_wr,
    input logic      data_wr,
    input logic      req_tx_n,
    input logic      req_rx_n
);

    // R5
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.dual |=> (req_tx_n == $past(!((ctrl.rx_en && rx_full) || (ctrl.tx_en && tx_empty)))));

    // R6
    dual_tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.dual |=> (req_tx_n == $past(!(ctrl.tx_en && tx_empty))));

    // R6
    dual_rx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.dual |=> (req_rx_n == $past(!(ctrl.rx_en && rx_full))));

    // R7
    idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.dual |=> req_rx_n);

    // R9
    rx_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rx_wr |=> rx_full);

    // R10
    tx_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !tx_empty);

endmodule

bind hrq_port hrq_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl_q),
    .rx_full    (rx_full),
    .tx_empty   (tx_empty),
    .core_rx_wr (core_rx_wr),
    .data_wr    (data_wr),
    .req_tx_n   (req_tx_n),
    .req_rx_n   (req_rx_n)
);

// File: tb/hrq_port_test.sv
module hrq_port_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_sel = 0, host_wr = 0;
    logic [1:0]    host_addr = 0;
    logic [DW-1:0] host_wdata = 0;
    logic [DW-1:0] host_rdata;
    logic          core_rx_wr = 0;
    logic [DW-1:0] core_rx_data = 0;
    logic          core_tx_rd = 0;
    logic [DW-1:0] core_tx_data;
    logic          host_ack = 0;
    logic          req_tx_n, req_rx_n;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model
    logic [2:0]    m_ctrl;
    logic          m_rxf, m_txe, m_ack;
    logic [DW-1:0] m_rxd, m_txd;
    logic [DW-1:0] last_rdata, last_txdata;

    always #4 clk = ~clk;

    hrq_port #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_rx_wr(core_rx_wr), .core_rx_data(core_rx_data), .core_tx_rd(core_tx_rd),
        .core_tx_data(core_tx_data), .host_ack(host_ack),
        .req_tx_n(req_tx_n), .req_rx_n(req_rx_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_a(input logic [2:0] c, input logic rxf, input logic txe);
        if (c[2]) return !(c[1] && txe);
        return !((c[0] && rxf) || (c[1] && txe));
    endfunction

    function automatic logic exp_b(input logic [2:0] c, input logic rxf);
        if (c[2]) return !(c[0] && rxf);
        return 1'b1;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {{(DW-3){1'b0}}, m_ctrl};
            2'd1:    return {{(DW-3){1'b0}}, m_ack, m_txe, m_rxf};
            2'd2:    return m_rxd;
            default: return '0;
        endcase
    endfunction

    task automatic cyc(input logic sel, input logic wr, input logic [1:0] a,
                       input logic [DW-1:0] wd, input logic crx, input logic [DW-1:0] crxd,
                       input logic ctx, input logic ack);
        logic ea, eb, rd, wdat;
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_addr = a; host_wdata = wd;
        core_rx_wr = crx; core_rx_data = crxd; core_tx_rd = ctx; host_ack = ack;
        #1;
        last_rdata  = host_rdata;
        last_txdata = core_tx_data;
        if (sel && !wr)
            chk(a == 2'd0 ? "R1 ctrl read" : a == 2'd1 ? "R8 status read" :
                a == 2'd2 ? "R3 data read" : "R1 unused read", host_rdata, exp_read(a));
        if (ctx) chk("R4 core tx data", core_tx_data, m_txd);
        ea = exp_a(m_ctrl, m_rxf, m_txe);
        eb = exp_b(m_ctrl, m_rxf);
        rd   = sel && !wr && a == 2'd2;
        wdat = sel && wr && a == 2'd2;
        @(posedge clk);
        #1;
        chk(m_ctrl[2] ? "R6 pin A" : "R5 pin A", req_tx_n, ea);
        chk(m_ctrl[2] ? "R6 pin B" : "R7 pin B", req_rx_n, eb);
        if (sel && wr && a == 2'd0) m_ctrl = wd[2:0];
        if (rd)  m_rxf = 1'b0;
        if (crx) begin m_rxf = 1'b1; m_rxd = crxd; end
        if (ctx) m_txe = 1'b1;
        if (wdat) begin m_txe = 1'b0; m_txd = wd; end
        m_ack = ack;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_ctrl = 0; m_rxf = 0; m_txe = 1; m_ack = 0; m_rxd = 0; m_txd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        #1;
        chk("R2 pin A", req_tx_n, 1);
        chk("R2 pin B", req_rx_n, 1);
        chk("R2 tx word", core_tx_data, 0);
        host_addr = 2'd1; #1; chk("R2 status", host_rdata, 8'h02);
        host_addr = 2'd0; #1; chk("R2 ctrl", host_rdata, 0);
        host_addr = 2'd2; #1; chk("R2 rx word", host_rdata, 0);
        idle(2);

        // R7 polling: no enables, flags active, no request
        cyc(0, 0, 0, 0, 1, 8'h5A, 0, 0);
        idle(2);
        chk("R7 polled pin A", req_tx_n, 1);

        // R1 control write and readback, single mode rx only (R5)
        cyc(1, 1, 0, 8'hF9, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        idle(2);
        chk("R5 rx-only request", req_tx_n, 0);
        cyc(1, 0, 2, 0, 0, 0, 0, 0);   // R3 read drains
        idle(2);
        chk("R3 drained no request", req_tx_n, 1);

        // R6 dual mode, transmit only
        cyc(1, 1, 0, 8'h06, 0, 0, 0, 0);
        idle(2);
        chk("R6 tx pin", req_tx_n, 0);
        chk("R6 rx pin idle", req_rx_n, 1);
        cyc(0, 0, 0, 0, 1, 8'h33, 0, 0);
        idle(2);
        chk("R6 rx disabled stays high", req_rx_n, 1);

        // R8 acknowledge sampled, no flag effect
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        cyc(1, 0, 1, 0, 0, 0, 0, 0);
        chk("R8 ack bit", last_rdata[2], 1);
        chk("R8 flags kept", last_rdata[1:0], 2'b11);

        // R9 receive collision
        cyc(1, 0, 2, 0, 1, 8'hC4, 0, 0);
        chk("R9 old word read", last_rdata, 8'h33);
        cyc(1, 0, 1, 0, 0, 0, 0, 0);
        chk("R9 rx_full kept", last_rdata[0], 1);
        cyc(1, 0, 2, 0, 0, 0, 0, 0);
        chk("R9 new word", last_rdata, 8'hC4);

        // R10 transmit collision
        cyc(1, 1, 2, 8'h71, 0, 0, 0, 0);
        cyc(1, 1, 2, 8'h92, 0, 0, 1, 0);
        chk("R10 core got old", last_txdata, 8'h71);
        cyc(1, 0, 1, 0, 0, 0, 0, 0);
        chk("R10 tx_empty low", last_rdata[1], 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R10 new word", last_txdata, 8'h92);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic s, w, crx, ctx, ak;
            logic [1:0] a;
            logic [DW-1:0] wd, cd;
            s   = ($urandom % 3) != 0;
            w   = $urandom % 2;
            a   = 2'($urandom);
            wd  = 8'($urandom);
            cd  = 8'($urandom);
            crx = ($urandom % 4) == 0;
            ctx = ($urandom % 4) == 0;
            ak  = $urandom % 2;
            cyc(s, w, a, wd, crx, cd, ctx, ak);
        end
        idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule